// File: doc/BRIEF.md
# Banked Memory Mapper with ROM Overlay

This block sits between a processor that drives a 16-bit address and a physical memory system that is larger than 64K. The processor's address space is cut into four 16K windows, chosen by the two highest address bits. Each window owns an 8-bit bank register. The physical address is that bank number placed above the low 14 address bits, which gives a 22-bit physical address. Bit 7 of the bank number decides whether reads from the window go to ROM or to RAM.

Bank registers are loaded through a separate I/O port, never through a memory address. Each window also has an overlay flag. When the flag is set, reads from the window still come from the ROM bank, but writes go to the RAM bank with the same low seven bank bits. This lets code that runs from ROM fill the RAM under its own window before that RAM is mapped in for reads. The decode is combinational, so the selects and strobes follow the processor's request in the same cycle. Register writes take effect at the next clock edge.

Top module: `bank_mapper`

## Requirements
- R1: After reset, window 0 maps bank 0x80 (ROM bank 0), windows 1, 2 and 3 map banks 0x01, 0x02 and 0x03 (RAM), and every overlay flag is clear.
- R2: For any access that is not an overlay write, `phys_addr` equals the bank register of window `cpu_addr[15:14]` in bits 21:14, followed by `cpu_addr[13:0]`.
- R3: A read (`mem_rd`=1, `mem_wr`=0) from a window whose bank bit 7 is 1 asserts `rom_cs` and `rom_oe` and no RAM signal. With bank bit 7 at 0, the read asserts `ram_cs` and `ram_oe` and no ROM signal.
- R4: A write (`mem_wr`=1, `mem_rd`=0) to a window whose bank bit 7 is 0 asserts `ram_cs` and `ram_we` and no other strobe.
- R5: A write to a window whose bank bit 7 is 1 and whose overlay flag is clear asserts no select and no strobe.
- R6: A write to a window whose overlay flag is set asserts `ram_cs` and `ram_we`. `phys_addr` is then 0 in bit 21, bank bits 6:0 in bits 20:14, and `cpu_addr[13:0]` below.
- R7: Setting a window's overlay flag does not change reads from it. A ROM-mapped window still reads from ROM at the R2 address.
- R8: An I/O write with `io_port` 0x00 to 0x03 loads `io_wdata` into the bank register of window 0 to 3. `io_port` 0x04 loads `io_wdata[3:0]` into the overlay flags, where bit n belongs to window n. Any other port value changes nothing.
- R9: An I/O write takes effect from the clock edge on which it is captured. A memory access in the same cycle as the I/O write still uses the old mapping.
- R10: With neither or both of `mem_rd` and `mem_wr` asserted, no select and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor memory address |
| mem_rd | input | 1 | Memory read request |
| mem_wr | input | 1 | Memory write request |
| io_wr | input | 1 | I/O write strobe for the mapping registers |
| io_port | input | 8 | I/O port number of the register write |
| io_wdata | input | 8 | I/O write data |
| phys_addr | output | 22 | Translated physical address |
| rom_cs | output | 1 | ROM select |
| rom_oe | output | 1 | ROM output enable |
| ram_cs | output | 1 | RAM select |
| ram_oe | output | 1 | RAM output enable |
| ram_we | output | 1 | RAM write enable |

## Verification
A register update and a memory access can arrive in the same cycle. A bank or overlay write can land while a read or write is already being decoded through the window it changes. The bench drives `io_wr` together with a memory access to the affected window. It checks that the access in that cycle uses the old bank and overlay setting, and that the next access uses the new one. Overlay writes and overlay reads to the same address are also placed back to back, so both paths of a single window are judged against the same register state.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 8,
  parameter int WIN_BITS = 2,
  parameter int PORT_W   = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               cpu_addr,
  input  logic                            mem_rd,
  input  logic                            mem_wr,
  input  logic                            io_wr,
  input  logic [PORT_W-1:0]               io_port,
  input  logic [7:0]                      io_wdata,
  output logic [BANK_W+ADDR_W-WIN_BITS-1:0] phys_addr,
  output logic                            rom_cs,
  output logic                            rom_oe,
  output logic                            ram_cs,
  output logic                            ram_oe,
  output logic                            ram_we
);
  localparam int NWIN  = 1 << WIN_BITS;
  localparam int OFF_W = ADDR_W - WIN_BITS;
  localparam logic [PORT_W-1:0] OV_PORT = PORT_W'(NWIN);

  logic [BANK_W-1:0] bank_q [NWIN];
  logic [NWIN-1:0]   ov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++)
        bank_q[i] <= (i == 0) ? {1'b1, {(BANK_W-1){1'b0}}} : BANK_W'(i);
      ov_q <= '0;
    end else if (io_wr) begin
      if (io_port < OV_PORT)
        bank_q[io_port[WIN_BITS-1:0]] <= io_wdata[BANK_W-1:0];
      else if (io_port == OV_PORT)
        ov_q <= io_wdata[NWIN-1:0];
    end
  end

  logic [WIN_BITS-1:0] win;
  logic [BANK_W-1:0]   cur;
  logic                rd_op, wr_op, to_rom, ov_w;

  assign win    = cpu_addr[ADDR_W-1 -: WIN_BITS];
  assign cur    = bank_q[win];
  assign ov_w   = ov_q[win];
  assign to_rom = cur[BANK_W-1];
  assign rd_op  = mem_rd & ~mem_wr;
  assign wr_op  = mem_wr & ~mem_rd;

  assign phys_addr = {(wr_op & ov_w) ? {1'b0, cur[BANK_W-2:0]} : cur,
                      cpu_addr[OFF_W-1:0]};

  assign rom_oe = rd_op & to_rom;
  assign rom_cs = rom_oe;
  assign ram_oe = rd_op & ~to_rom;
  assign ram_we = wr_op & (ov_w | ~to_rom);
  assign ram_cs = ram_oe | ram_we;
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              io_wr,
  input logic [PHYS_W-1:0] phys_addr,
  input logic              rom_cs,
  input logic              rom_oe,
  input logic              ram_cs,
  input logic              ram_oe,
  input logic              ram_we
);
  a_r3_one_device: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs}));

  a_r3_rom_only_reads: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> (mem_rd && !mem_wr && !ram_we && !ram_oe));

  a_r4_we_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (mem_wr && !mem_rd && ram_cs && !ram_oe));

  a_r6_ram_write_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !phys_addr[PHYS_W-1]);

  a_r3_ram_read_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    ram_oe |-> !phys_addr[PHYS_W-1]);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd == mem_wr) |-> !(rom_cs || ram_cs || ram_we || ram_oe || rom_oe));

  a_r9_map_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr && mem_rd && !mem_wr) |=>
      ((mem_rd && !mem_wr && $stable(cpu_addr)) |->
        ($stable(phys_addr) && $stable(rom_cs))));
endmodule

bind bank_mapper bank_mapper_chk #(.ADDR_W(ADDR_W), .PHYS_W(BANK_W+ADDR_W-WIN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_wr(io_wr), .phys_addr(phys_addr), .rom_cs(rom_cs), .rom_oe(rom_oe),
  .ram_cs(ram_cs), .ram_oe(ram_oe), .ram_we(ram_we));

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_port = '0, io_wdata = '0;
  logic [21:0] phys_addr;
  logic        rom_cs, rom_oe, ram_cs, ram_oe, ram_we;

  int errors = 0, checks = 0;
  logic [7:0] m_bank [4];
  logic [3:0] m_ov;

  always #(CLK_P/2) clk = ~clk;

  bank_mapper u_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_wr(io_wr), .io_port(io_port), .io_wdata(io_wdata), .phys_addr(phys_addr),
    .rom_cs(rom_cs), .rom_oe(rom_oe), .ram_cs(ram_cs), .ram_oe(ram_oe), .ram_we(ram_we));

  function automatic logic [26:0] expect_out(logic [15:0] a, logic rd, logic wr);
    logic [7:0] b;
    logic ov, r, w;
    logic [21:0] p;
    b  = m_bank[a[15:14]];
    ov = m_ov[a[15:14]];
    r  = rd && !wr;
    w  = wr && !rd;
    p  = (w && ov) ? {1'b0, b[6:0], a[13:0]} : {b, a[13:0]};
    return {p, r && b[7], r && b[7], (r && !b[7]) || (w && (ov || !b[7])),
            r && !b[7], w && (ov || !b[7])};
  endfunction

  task automatic access(string tag, logic [15:0] a, logic rd, logic wr);
    logic [26:0] exp_v, act;
    @(negedge clk);
    cpu_addr = a; mem_rd = rd; mem_wr = wr;
    exp_v = expect_out(a, rd, wr);
    #(CLK_P/4);
    act = {phys_addr, rom_cs, rom_oe, ram_cs, ram_oe, ram_we};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h rd=%0b wr=%0b act=%h exp=%h", tag, a, rd, wr, act, exp_v);
    end
  endtask

  task automatic io_write(logic [7:0] port, logic [7:0] data);
    @(negedge clk);
    mem_rd = 0; mem_wr = 0;
    io_wr = 1; io_port = port; io_wdata = data;
    @(posedge clk);
    #1 io_wr = 0;
    if (port < 8'd4) m_bank[port[1:0]] = data;
    else if (port == 8'd4) m_ov = data[3:0];
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_bank[0] = 8'h80; m_bank[1] = 8'h01; m_bank[2] = 8'h02; m_bank[3] = 8'h03;
    m_ov = 4'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    for (int w = 0; w < 4; w++) access("R1 reset map", {w[1:0], 14'h1A5}, 1, 0);
    access("R10 idle", 16'h4000, 0, 0);
    access("R10 both", 16'h8000, 1, 1);
    access("R5 rom write ignored", 16'h0123, 0, 1);
    access("R4 ram write", 16'h7FFF, 0, 1);

    io_write(8'h04, 8'h01);
    access("R6 overlay write", 16'h2345, 0, 1);
    access("R7 overlay read", 16'h2345, 1, 0);
    io_write(8'h01, 8'h85);
    access("R6 overlay off ram bank", 16'h4001, 0, 1);
    access("R5 rom window no overlay", 16'h4001, 0, 1);
    io_write(8'h07, 8'hFF);
    access("R8 bad port ignored", 16'hC000, 1, 0);
    access("R8 bad port ignored ov", 16'h8000, 0, 1);

    @(negedge clk);
    cpu_addr = 16'h0010; mem_rd = 0; mem_wr = 1;
    io_wr = 1; io_port = 8'h04; io_wdata = 8'h00;
    #(CLK_P/4);
    checks++;
    if (!(ram_we && phys_addr == 22'h000010)) begin
      errors++;
      $display("FAIL R9 same-cycle act=%0b/%h exp=1/000010", ram_we, phys_addr);
    end
    @(posedge clk);
    #1 io_wr = 0; m_ov = 4'h0;
    access("R9 new map applies", 16'h0010, 0, 1);

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0)
        io_write(8'($urandom_range(0, 6)), 8'($urandom));
      else begin
        int k = $urandom_range(0, 9);
        access("R2 R3 R4 random", 16'($urandom), k < 5, k >= 4);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule